// File: doc/BRIEF.md
# Tetrahedral 3D Color Lattice Transform

This block recolours a stream of RGB pixels through a cubic lattice of 17 points per axis, 4913 output colours in all. Each input pixel selects the lattice cell that contains it. The block then picks one of the six tetrahedra that fill that cell and blends the tetrahedron's four corner colours, weighting each corner by the pixel's fractional position. The result goes out on a valid/ready stream with a fixed two-cycle latency when nothing stalls.

Lattice contents arrive on a separate load port, one entry per cycle in linear order. Each channel of an entry is 32 bits wide, and the block cuts it down to the storage precision that a mode pin selects. The entries are dealt round-robin into four single-port banks. A ready flag shows that a complete lattice is present. An error flag reports a load session that ended with no entries at all. A sticky flag records attempts to write past the end of the lattice.

A bypass pin forwards pixels unchanged. Pixels also pass through unchanged whenever no complete lattice is loaded.

Top module: `tetra_clut3d`

## Requirements
- R1: After reset, `px_out_valid`, `lut_ready`, `lut_ovf` and `lut_err` are all 0, and `px_in_ready` is 1.
- R2: Load entries are numbered from 0 in arrival order. Entry n holds the lattice point with red index n/289, green index (n/17) mod 17 and blue index n mod 17, so n = r*289 + g*17 + b. Entry n is stored in bank n mod 4 at word n div 4. `lut_ready` rises on the clock edge that takes entry 4912 and stays 0 while fewer entries have arrived.
- R3: Any load entry after the 4913th leaves the lattice unchanged and sets `lut_ovf`. The flag stays set until the next `ld_start`, and `ld_start` also clears `lut_ready`, `lut_err` and the entry count.
- R4: A `ld_done` pulse while the entry count is zero sets `lut_err` and leaves `lut_ready` at 0.
- R5: With `prec10`=0 a stored channel is bits 31:20 of the loaded word. With `prec10`=1 it is bits 31:22 followed by two zero bits.
- R6: Each 12-bit pixel channel splits into a cell index (bits 11:8, at most 15, so the upper corner index is at most 16) and a fraction f (bits 7:0).
- R7: Sort the fractions as hi ≥ mid ≥ lo. Corner c0 is the cell origin. c1 steps one point along the axis of hi. c2 steps further along the axis of mid. c3 is the far corner. The blend is acc = (256−hi)·c0 + (hi−mid)·c1 + (mid−lo)·c2 + lo·c3. With `prec10`=0 each output channel is (acc+128)>>8.
- R8: With `prec10`=1 each output channel is ((acc+512)>>10)<<2.
- R9: A pixel accepted while `bypass`=1 comes out equal to its input.
- R10: A pixel accepted while `lut_ready`=0 and `bypass`=0 comes out equal to its input.
- R11: Outputs leave in input order. `px_out_valid` and the output channels hold steady while `px_out_ready` is 0. `px_in_ready` is 0 while `ld_valid` is 1. A bank never reads and writes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prec10 | input | 1 | 1 selects 10-bit storage and output precision |
| bypass | input | 1 | 1 forwards pixels unchanged |
| ld_start | input | 1 | Begins a load session; clears count and flags |
| ld_valid | input | 1 | A lattice entry is present on the load channels |
| ld_r | input | 32 | Red value of the load entry |
| ld_g | input | 32 | Green value of the load entry |
| ld_b | input | 32 | Blue value of the load entry |
| ld_done | input | 1 | Ends a load session |
| lut_ready | output | 1 | A complete lattice is loaded |
| lut_ovf | output | 1 | Sticky: an entry past the lattice end was offered |
| lut_err | output | 1 | A session ended with no entries |
| px_in_valid | input | 1 | Input pixel valid |
| px_in_ready | output | 1 | Input pixel accepted when high with valid |
| px_in_r | input | 12 | Input red |
| px_in_g | input | 12 | Input green |
| px_in_b | input | 12 | Input blue |
| px_out_valid | output | 1 | Output pixel valid |
| px_out_ready | input | 1 | Downstream accepts output |
| px_out_r | output | 12 | Output red |
| px_out_g | output | 12 | Output green |
| px_out_b | output | 12 | Output blue |

## Verification
Some properties are checked on every cycle:
- the blend weights of every pixel in flight sum to 256;
- a stalled output holds steady;
- no bank is read and written in the same cycle;
- the error and ready flags are never set together;
- the overflow flag only rises once a full lattice is in place;
- the ready flag tracks a full entry count.

Other behaviour shows only in the bench's scenarios, which compare each output against a behavioural model:
- the bank interleave and the choice of tetrahedron across all six fraction orderings and their ties;
- the rounding in both precisions;
- the top input code;
- overflow entries leaving the lattice intact.

// File: rtl/clut_pkg.sv
package clut_pkg;
  localparam int GRID    = 17;
  localparam int ENTRIES = GRID * GRID * GRID;
  localparam int BANKS   = 4;                  // power of two
  localparam int BSW     = $clog2(BANKS);
  localparam int CW      = 12;                 // pixel / stored channel width
  localparam int FW      = 8;                  // fraction width
  localparam int IW      = CW - FW;            // cell index width
  localparam int LW      = 32;                 // load channel width
  localparam int WW      = FW + 1;             // blend weight width
  localparam int CNT_W   = $clog2(ENTRIES + 1);
  localparam int IDX_W   = $clog2(ENTRIES);
  localparam int AW      = $clog2((ENTRIES + BANKS - 1) / BANKS);
  localparam int ACC_W   = CW + FW;
  localparam int NCH     = 3;

  typedef logic [CW-1:0] chan_t;
  typedef logic [NCH-1:0][CW-1:0] rgb_t;       // [2]=red [1]=green [0]=blue
  typedef logic [3:0][WW-1:0] wts_t;
endpackage

// File: rtl/clut_loader.sv
module clut_loader
  import clut_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prec10,
  input  logic             ld_start,
  input  logic             ld_valid,
  input  logic [LW-1:0]    ld_r,
  input  logic [LW-1:0]    ld_g,
  input  logic [LW-1:0]    ld_b,
  input  logic             ld_done,
  output logic [BANKS-1:0] wr_en,
  output logic [AW-1:0]    wr_addr,
  output rgb_t             wr_data,
  output logic             lut_ready,
  output logic             lut_ovf,
  output logic             lut_err
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic init_q, init_d, ovf_q, ovf_d, err_q, err_d;

  function automatic chan_t shrink(input logic [LW-1:0] v, input logic p10);
    if (p10) return {(CW-2)'(v >> (LW - CW + 2)), 2'b00};
    return CW'(v >> (LW - CW));
  endfunction

  always_comb begin
    cnt_d  = cnt_q;
    init_d = init_q;
    ovf_d  = ovf_q;
    err_d  = err_q;
    wr_en  = '0;
    if (ld_start) begin
      cnt_d  = '0;
      init_d = 1'b0;
      ovf_d  = 1'b0;
      err_d  = 1'b0;
    end else begin
      if (ld_valid) begin
        if (cnt_q < CNT_W'(ENTRIES)) begin
          wr_en[cnt_q[BSW-1:0]] = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ENTRIES - 1)) init_d = 1'b1;
        end else begin
          ovf_d = 1'b1;
        end
      end
      if (ld_done && !ld_valid && cnt_q == '0) begin
        err_d  = 1'b1;
        init_d = 1'b0;
      end
    end
  end

  assign wr_addr = AW'(cnt_q >> BSW);
  assign wr_data = {shrink(ld_r, prec10), shrink(ld_g, prec10), shrink(ld_b, prec10)};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      init_q <= 1'b0;
      ovf_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      init_q <= init_d;
      ovf_q  <= ovf_d;
      err_q  <= err_d;
    end
  end

  assign lut_ready = init_q;
  assign lut_ovf   = ovf_q;
  assign lut_err   = err_q;

  AST_READY_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    init_q |-> cnt_q == CNT_W'(ENTRIES)); // R2
  AST_OVF_AFTER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_q) |-> $past(init_q)); // R3
  AST_ERR_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !init_q); // R4
endmodule

// File: rtl/clut_bank.sv
module clut_bank #(
  parameter int DEPTH = 1229,
  parameter int ADDR_W = 11,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/clut_vsel.sv
module clut_vsel
  import clut_pkg::*;
(
  input  logic [FW-1:0]    fr,
  input  logic [FW-1:0]    fg,
  input  logic [FW-1:0]    fb,
  output logic [IDX_W-1:0] off1,
  output logic [IDX_W-1:0] off2,
  output wts_t             w
);
  localparam logic [IDX_W-1:0] RS = IDX_W'(GRID * GRID);
  localparam logic [IDX_W-1:0] GS = IDX_W'(GRID);
  localparam logic [IDX_W-1:0] BS = IDX_W'(1);

  logic [FW-1:0] hi, mid, lo;
  logic rg, rb, gb;

  always_comb begin
    rg = fr >= fg;
    rb = fr >= fb;
    gb = fg >= fb;
    if (rg && rb) begin
      hi = fr; off1 = RS;
      if (gb) begin mid = fg; lo = fb; off2 = RS + GS; end
      else    begin mid = fb; lo = fg; off2 = RS + BS; end
    end else if (gb) begin
      hi = fg; off1 = GS;
      if (rb) begin mid = fr; lo = fb; off2 = GS + RS; end
      else    begin mid = fb; lo = fr; off2 = GS + BS; end
    end else begin
      hi = fb; off1 = BS;
      if (rg) begin mid = fr; lo = fg; off2 = BS + RS; end
      else    begin mid = fg; lo = fr; off2 = BS + GS; end
    end
    w[0] = WW'(1 << FW) - WW'(hi);
    w[1] = WW'(hi) - WW'(mid);
    w[2] = WW'(mid) - WW'(lo);
    w[3] = WW'(lo);
  end
endmodule

// File: rtl/clut_blend.sv
module clut_blend
  import clut_pkg::*;
(
  input  rgb_t       v [4],
  input  wts_t       w,
  input  logic       prec10,
  output rgb_t       y
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [ACC_W-1:0] acc;
    always_comb begin
      acc = '0;
      for (int k = 0; k < 4; k++)
        acc = acc + ACC_W'(w[k]) * ACC_W'(v[k][c]);
      if (prec10)
        y[c] = {(CW-2)'((acc + ACC_W'(1 << (FW + 1))) >> (FW + 2)), 2'b00};
      else
        y[c] = CW'((acc + ACC_W'(1 << (FW - 1))) >> FW);
    end
  end
endmodule

// File: rtl/tetra_clut3d.sv
module tetra_clut3d
  import clut_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prec10,
  input  logic          bypass,
  input  logic          ld_start,
  input  logic          ld_valid,
  input  logic [LW-1:0] ld_r,
  input  logic [LW-1:0] ld_g,
  input  logic [LW-1:0] ld_b,
  input  logic          ld_done,
  output logic          lut_ready,
  output logic          lut_ovf,
  output logic          lut_err,
  input  logic          px_in_valid,
  output logic          px_in_ready,
  input  logic [CW-1:0] px_in_r,
  input  logic [CW-1:0] px_in_g,
  input  logic [CW-1:0] px_in_b,
  output logic          px_out_valid,
  input  logic          px_out_ready,
  output logic [CW-1:0] px_out_r,
  output logic [CW-1:0] px_out_g,
  output logic [CW-1:0] px_out_b
);
  localparam logic [IDX_W-1:0] FAR = IDX_W'(GRID * GRID + GRID + 1);

  // reset: asserted asynchronously, released after two clock edges
  logic rs0_q, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs0_q <= 1'b0;
      rst_q <= 1'b0;
    end else begin
      rs0_q <= 1'b1;
      rst_q <= rs0_q;
    end
  end

  // load side
  logic [BANKS-1:0] wr_en;
  logic [AW-1:0]    wr_addr;
  rgb_t             wr_data;

  clut_loader u_loader (
    .clk(clk), .rst_n(rst_q), .prec10(prec10), .ld_start(ld_start),
    .ld_valid(ld_valid), .ld_r(ld_r), .ld_g(ld_g), .ld_b(ld_b),
    .ld_done(ld_done), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .lut_ready(lut_ready), .lut_ovf(lut_ovf), .lut_err(lut_err));

  // stage 0: cell, tetrahedron, bank addresses
  logic advance, in_fire;
  logic out_valid_q, s1_valid_q, s1_valid_d;
  assign advance     = !out_valid_q || px_out_ready;
  assign px_in_ready = advance && !ld_valid;
  assign in_fire     = px_in_valid && px_in_ready;

  logic [IDX_W-1:0] base, off1, off2;
  logic [IDX_W-1:0] vidx [4];
  logic [BSW-1:0]   base_bank;
  logic [AW-1:0]    rd_addr [BANKS];
  wts_t             w0;

  clut_vsel u_vsel (
    .fr(px_in_r[FW-1:0]), .fg(px_in_g[FW-1:0]), .fb(px_in_b[FW-1:0]),
    .off1(off1), .off2(off2), .w(w0));

  always_comb begin
    base = IDX_W'(px_in_r[CW-1:FW]) * IDX_W'(GRID * GRID)
         + IDX_W'(px_in_g[CW-1:FW]) * IDX_W'(GRID)
         + IDX_W'(px_in_b[CW-1:FW]);
    vidx[0] = base;
    vidx[1] = base + off1;
    vidx[2] = base + off2;
    vidx[3] = base + FAR;
    base_bank = base[BSW-1:0];
    for (int j = 0; j < BANKS; j++)
      rd_addr[j] = AW'(vidx[BSW'(j) - base_bank] >> BSW);
  end

  rgb_t bank_rd [BANKS];
  for (genvar j = 0; j < BANKS; j++) begin : g_bank
    localparam int DEPTH_J = (ENTRIES - j + BANKS - 1) / BANKS;
    clut_bank #(.DEPTH(DEPTH_J), .ADDR_W(AW), .DATA_W(NCH * CW)) u_bank (
      .clk(clk), .we(wr_en[j]), .re(in_fire),
      .addr(wr_en[j] ? wr_addr : rd_addr[j]),
      .wdata(wr_data), .rdata(bank_rd[j]));

    AST_BANK_ONE_OP: assert property (@(posedge clk) disable iff (!rst_q)
      !(wr_en[j] && in_fire)); // R11
  end

  // stage 1: blend
  rgb_t           s1_pix;
  logic           s1_pass, s1_p10;
  wts_t           s1_w;
  logic [BSW-1:0] s1_rot;
  rgb_t           vtx [4];
  rgb_t           blend, out_d;
  rgb_t           out_q;

  assign s1_valid_d = advance ? in_fire : s1_valid_q;

  always_ff @(posedge clk) begin
    if (in_fire) begin
      s1_pix  <= {px_in_r, px_in_g, px_in_b};
      s1_pass <= bypass || !lut_ready;
      s1_p10  <= prec10;
      s1_w    <= w0;
      s1_rot  <= base_bank;
    end
  end

  always_comb begin
    for (int k = 0; k < 4; k++)
      vtx[k] = bank_rd[BSW'(k) + s1_rot];
  end

  clut_blend u_blend (.v(vtx), .w(s1_w), .prec10(s1_p10), .y(blend));

  assign out_d = s1_pass ? s1_pix : blend;

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      s1_valid_q  <= 1'b0;
      out_valid_q <= 1'b0;
    end else begin
      s1_valid_q <= s1_valid_d;
      if (advance) out_valid_q <= s1_valid_q;
    end
  end

  always_ff @(posedge clk) begin
    if (advance && s1_valid_q) out_q <= out_d;
  end

  assign px_out_valid = out_valid_q;
  assign px_out_r     = out_q[2];
  assign px_out_g     = out_q[1];
  assign px_out_b     = out_q[0];

  AST_WEIGHT_SUM: assert property (@(posedge clk) disable iff (!rst_q)
    s1_valid_q |-> (s1_w[0] + s1_w[1] + s1_w[2] + s1_w[3]) == WW'(1 << FW)); // R7
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_q)
    px_out_valid && !px_out_ready |=> px_out_valid && $stable(px_out_r)
      && $stable(px_out_g) && $stable(px_out_b)); // R11
endmodule

// File: tb/tetra_clut3d_test.sv
`timescale 1ns/1ps
module tetra_clut3d_test;
  localparam int NENT = 17 * 17 * 17;

  logic clk = 1'b0;
  logic rst_n, prec10, bypass, ld_start, ld_valid, ld_done;
  logic [31:0] ld_r, ld_g, ld_b;
  logic lut_ready, lut_ovf, lut_err;
  logic px_in_valid, px_in_ready, px_out_valid, px_out_ready;
  logic [11:0] px_in_r, px_in_g, px_in_b, px_out_r, px_out_g, px_out_b;

  always #2.5 clk = ~clk;

  tetra_clut3d uut (
    .clk(clk), .rst_n(rst_n), .prec10(prec10), .bypass(bypass),
    .ld_start(ld_start), .ld_valid(ld_valid), .ld_r(ld_r), .ld_g(ld_g), .ld_b(ld_b),
    .ld_done(ld_done), .lut_ready(lut_ready), .lut_ovf(lut_ovf), .lut_err(lut_err),
    .px_in_valid(px_in_valid), .px_in_ready(px_in_ready),
    .px_in_r(px_in_r), .px_in_g(px_in_g), .px_in_b(px_in_b),
    .px_out_valid(px_out_valid), .px_out_ready(px_out_ready),
    .px_out_r(px_out_r), .px_out_g(px_out_g), .px_out_b(px_out_b));

  int checks = 0;
  int fails = 0;
  int lat [NENT][3];
  int ld_cnt = 0;
  bit stall_en = 0;
  logic [35:0] exp_q [$];
  string tag_q [$];
  logic [35:0] e_cur;
  string t_cur;

  function automatic int ent(input int i, input int c);
    return (i * (37 + c * 12) + c * 977 + (i >> 3) * 5) % 4096;
  endfunction

  // behavioural model of one pixel (R6, R7, R8)
  function automatic logic [35:0] model(input int r, input int g, input int b, input bit p10);
    int fr[3], st[3], base, v0, v1, v2, v3, acc, o[3], tf, ts;
    fr[0] = r & 255; fr[1] = g & 255; fr[2] = b & 255;
    st[0] = 289; st[1] = 17; st[2] = 1;
    base = (r >> 8) * 289 + (g >> 8) * 17 + (b >> 8);
    for (int a = 0; a < 2; a++)
      for (int c = 0; c < 2 - a; c++)
        if (fr[c] < fr[c+1]) begin
          tf = fr[c]; fr[c] = fr[c+1]; fr[c+1] = tf;
          ts = st[c]; st[c] = st[c+1]; st[c+1] = ts;
        end
    v0 = base; v1 = v0 + st[0]; v2 = v1 + st[1]; v3 = v2 + st[2];
    for (int ch = 0; ch < 3; ch++) begin
      acc = (256 - fr[0]) * lat[v0][ch] + (fr[0] - fr[1]) * lat[v1][ch]
          + (fr[1] - fr[2]) * lat[v2][ch] + fr[2] * lat[v3][ch];
      o[ch] = p10 ? (((acc + 512) >> 10) << 2) : ((acc + 128) >> 8);
    end
    return {12'(o[0]), 12'(o[1]), 12'(o[2])};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // scoreboard: sampled away from the active edge
  always @(negedge clk) begin
    if (px_out_valid && px_out_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R11: output %h with nothing expected", {px_out_r, px_out_g, px_out_b});
      end else begin
        e_cur = exp_q.pop_front();
        t_cur = tag_q.pop_front();
        if ({px_out_r, px_out_g, px_out_b} !== e_cur) begin
          fails++;
          $display("FAIL %s: actual %h expected %h", t_cur,
                   {px_out_r, px_out_g, px_out_b}, e_cur);
        end
      end
    end
    if (px_in_valid && px_in_ready) begin
      if (bypass) begin
        exp_q.push_back({px_in_r, px_in_g, px_in_b}); tag_q.push_back("R9");
      end else if (!lut_ready) begin
        exp_q.push_back({px_in_r, px_in_g, px_in_b}); tag_q.push_back("R10");
      end else begin
        exp_q.push_back(model(px_in_r, px_in_g, px_in_b, prec10));
        tag_q.push_back(prec10 ? "R8" : "R7");
      end
    end
  end

  always begin
    @(posedge clk); #1;
    px_out_ready = stall_en ? ($urandom % 3 != 0) : 1'b1;
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic start_load();
    ld_start = 1'b1; tick(); ld_start = 1'b0;
    ld_cnt = 0;
  endtask

  // entry n is lattice point n = r*289 + g*17 + b (R2); low bits carry junk (R5)
  task automatic load(input int n, input int salt);
    for (int i = 0; i < n; i++) begin
      ld_valid = 1'b1;
      ld_r = {12'(ent(i + salt, 0)), 20'h5A5A5};
      ld_g = {12'(ent(i + salt, 1)), 20'hFFFFF};
      ld_b = {12'(ent(i + salt, 2)), 20'h00001};
      if (ld_cnt < NENT)
        for (int c = 0; c < 3; c++)
          lat[ld_cnt][c] = prec10 ? (ent(i + salt, c) & 'hFFC) : ent(i + salt, c);
      ld_cnt++;
      if (i == 0) begin
        @(negedge clk);
        chk(px_in_ready == 1'b0, "R11 in_ready during load", px_in_ready, 0);
      end
      tick();
    end
    ld_valid = 1'b0;
  endtask

  task automatic send(input int r, input int g, input int b);
    px_in_valid = 1'b1;
    px_in_r = 12'(r); px_in_g = 12'(g); px_in_b = 12'(b);
    do @(negedge clk); while (!px_in_ready);
    tick();
    px_in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && exp_q.size() != 0; k++) tick();
    chk(exp_q.size() == 0, "R11 all outputs delivered", exp_q.size(), 0);
  endtask

  task automatic pixel_set();
    send(0, 0, 0);
    send(4095, 4095, 4095);          // top code, far corner 16 (R6)
    send(255, 255, 255);             // all fractions tie
    send(12'h300, 12'h500, 12'hA00); // exact lattice point
    send(200, 100, 50);   send(200 + 256, 50, 100 + 512);
    send(100, 200 + 768, 50); send(50, 200, 100 + 1024);
    send(100 + 2048, 50, 200); send(50, 100, 200 + 3840);
    send(128, 128, 7);    send(9, 128, 128);
    for (int k = 0; k < 30; k++) send($urandom % 4096, $urandom % 4096, $urandom % 4096);
  endtask

  initial begin
    rst_n = 1'b0; prec10 = 1'b0; bypass = 1'b0; ld_start = 1'b0; ld_valid = 1'b0;
    ld_done = 1'b0; ld_r = '0; ld_g = '0; ld_b = '0;
    px_in_valid = 1'b0; px_in_r = '0; px_in_g = '0; px_in_b = '0; px_out_ready = 1'b1;
    repeat (3) tick();
    // R1
    chk(px_out_valid == 1'b0, "R1 out_valid", px_out_valid, 0);
    chk(lut_ready == 1'b0, "R1 lut_ready", lut_ready, 0);
    chk(lut_ovf == 1'b0, "R1 lut_ovf", lut_ovf, 0);
    chk(lut_err == 1'b0, "R1 lut_err", lut_err, 0);
    rst_n = 1'b1;
    repeat (3) tick();
    chk(px_in_ready == 1'b1, "R1 in_ready", px_in_ready, 1);

    // R4: empty session
    start_load();
    ld_done = 1'b1; tick(); ld_done = 1'b0;
    chk(lut_err == 1'b1, "R4 lut_err", lut_err, 1);
    chk(lut_ready == 1'b0, "R4 lut_ready", lut_ready, 0);

    // R10: no lattice -> pass-through
    send(100, 2000, 4095); send(7, 8, 9);
    drain();

    // R2, R5 in 12-bit mode
    start_load();
    chk(lut_err == 1'b0, "R3 start clears err", lut_err, 0);
    load(NENT - 1, 0);
    chk(lut_ready == 1'b0, "R2 not ready at 4912", lut_ready, 0);
    load(1, NENT - 1);
    chk(lut_ready == 1'b1, "R2 ready at 4913", lut_ready, 1);
    chk(lut_ovf == 1'b0, "R3 no ovf yet", lut_ovf, 0);
    load(3, 77);                     // R3: ignored extras
    chk(lut_ovf == 1'b1, "R3 ovf set", lut_ovf, 1);
    chk(lut_ready == 1'b1, "R3 ready kept", lut_ready, 1);
    ld_done = 1'b1; tick(); ld_done = 1'b0;
    chk(lut_err == 1'b0, "R4 done with entries", lut_err, 0);

    // R7 with and without back-pressure (R11)
    pixel_set();
    drain();
    stall_en = 1;
    pixel_set();
    drain();

    // R9 bypass
    bypass = 1'b1;
    send(1, 2, 3); send(4095, 0, 2048); send(300, 301, 302);
    bypass = 1'b0;
    drain();
    stall_en = 0;

    // R8, R5 in 10-bit mode
    prec10 = 1'b1;
    start_load();
    chk(lut_ovf == 1'b0, "R3 start clears ovf", lut_ovf, 0);
    chk(lut_ready == 1'b0, "R3 start clears ready", lut_ready, 0);
    load(NENT, 0);
    chk(lut_ready == 1'b1, "R2 ready after reload", lut_ready, 1);
    stall_en = 1;
    pixel_set();
    drain();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule